// File: doc/BRIEF.md
# Shadowed Parallel-Video Timing Generator

This block paces a parallel pixel interface. Two cascaded counters walk through every line and every frame. The horizontal counter counts pixels and the vertical counter counts lines. From these counters the block decodes active-high sync pulses and a data-enable window. While the window is open, it pulls pixel words from an upstream buffer. If the buffer has no word ready at that moment, the block drives a programmable fill word. It also records an underrun interrupt, unless the current line index is below a programmable floor. Software reads the interrupt both raw and masked, and clears it with a one-cycle pulse.

Software presents the timing values on staged configuration inputs, then pulses an update strobe. The working copy takes the staged values at the first frame boundary after the strobe, so one frame never mixes two timings. While the generator is disabled, the working copy takes them at the next clock edge. Within each line, and within each frame, the segments run in a fixed order: sync, then the gap, then the active region, then the front porch. The front porch is whatever count is left before the total.

The pixel input is a valid/ready stream with one rule: ready is simply the data-enable window and never waits for valid. Timing is never stalled. A word that arrives late is not taken, and the fill word stands in for it. Three sideband control bits pass straight through to the interface.

Top module: `vtg_dpi_timing`

## Requirements
- R1: After reset the sync outputs, data-enable, pixel output and both interrupt outputs are low. The working timing is 800 total / 640 active / 96 sync / 48 gap pixels and 525 total / 480 active / 2 sync / 33 gap lines.
- R2: With the generator running, the pixel count starts at 0 and advances by one each clock. hsync is high for counts below the sync width. The active window spans counts sync+gap up to sync+gap+active-1. The count returns to 0 after total-1.
- R3: The line count advances when the pixel count wraps and returns to 0 after the total minus one. vsync is high on lines below the vertical sync width. The vertical active window spans lines sync+gap up to sync+gap+active-1.
- R4: Data-enable is high only when both the horizontal and the vertical active windows hold. All syncs are active high.
- R5: A pulse on cfg_update copies all eight staged timing inputs into the working timing at the next frame end (the clock edge where both counters wrap). When run_en is low, the copy happens at the next edge. The working timing changes at no other time.
- R6: pix_ready equals data-enable. When pix_valid and data-enable are both high, pix_out equals pix_data. pix_out is zero outside data-enable.
- R7: When data-enable is high and pix_valid is low, pix_out equals fill_word.
- R8: Such an underflow sets irq_raw at the next edge when the line count is at least irq_line_min. An underflow on a lower line leaves irq_raw unchanged.
- R9: irq_clear high for a cycle lowers irq_raw at the next edge. If an underflow that counts falls in that same cycle, irq_raw stays high.
- R10: irq_status equals irq_raw AND irq_enable.
- R11: While run_en is low, both counters are held at 0 and hsync, vsync, data-enable and pix_ready stay low.
- R12: out_shutdown, out_colour and out_refresh follow ctl_shutdown, ctl_colour and ctl_refresh in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Master enable for the timing counters and video outputs |
| cfg_h_total | input | 12 | Staged pixels per line |
| cfg_h_active | input | 12 | Staged active pixels per line |
| cfg_h_sync | input | 12 | Staged hsync width in pixels |
| cfg_h_gap | input | 12 | Staged pixels from sync end to active start |
| cfg_v_total | input | 12 | Staged lines per frame |
| cfg_v_active | input | 12 | Staged active lines |
| cfg_v_sync | input | 12 | Staged vsync width in lines |
| cfg_v_gap | input | 12 | Staged lines from sync end to active start |
| cfg_update | input | 1 | One-cycle strobe that arms the staged-to-working copy |
| fill_word | input | 30 | Word driven when the buffer underflows |
| irq_line_min | input | 12 | Lowest line index on which an underflow raises the interrupt |
| irq_enable | input | 1 | Mask for irq_status |
| irq_clear | input | 1 | One-cycle pulse that clears irq_raw |
| pix_valid | input | 1 | Upstream word valid |
| pix_data | input | 30 | Upstream pixel word |
| pix_ready | output | 1 | Word consumed this cycle (equals data-enable) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pix_out | output | 30 | Pixel word to the interface |
| irq_raw | output | 1 | Raw underrun interrupt |
| irq_status | output | 1 | Masked underrun interrupt |
| ctl_shutdown | input | 1 | Shutdown sideband control |
| ctl_colour | input | 1 | Colour-mode sideband control |
| ctl_refresh | input | 1 | Update-config sideband control |
| out_shutdown | output | 1 | Shutdown sideband to the interface |
| out_colour | output | 1 | Colour-mode sideband to the interface |
| out_refresh | output | 1 | Update-config sideband to the interface |

## Verification
Two collisions matter in this block. The first is an underflow that counts landing in the same cycle as an interrupt-clear pulse. The bench provokes it by dropping pix_valid on an active pixel of a line above the floor while pulsing irq_clear in that same cycle. It then expects irq_raw to stay high on the next cycle. The second is an update strobe arriving mid-frame, which must wait for the frame boundary. The bench models the armed strobe and the wrap edge itself and compares hsync, vsync, data-enable, pix_out and both interrupt bits on every cycle across four frames, covering old timing, the switch and new timing.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  parameter int unsigned VTG_CW = 12;
  parameter int unsigned VTG_PW = 30;

  // one axis of timing: the segments run sync, gap, active, front porch
  typedef struct packed {
    logic [VTG_CW-1:0] total;
    logic [VTG_CW-1:0] act;
    logic [VTG_CW-1:0] sync;
    logic [VTG_CW-1:0] gap;
  } vtg_axis_t;
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              step,
  input  vtg_axis_t         cfg,
  output logic [VTG_CW-1:0] cnt,
  output logic              last,
  output logic              sync_win,
  output logic              act_win
);
  localparam int unsigned SW = VTG_CW + 2;

  logic [SW-1:0] cnt_x, act_lo, act_hi;

  assign cnt_x    = SW'(cnt);
  assign act_lo   = SW'(cfg.sync) + SW'(cfg.gap);
  assign act_hi   = act_lo + SW'(cfg.act);
  assign last     = en && step && ((cnt_x + SW'(1)) >= SW'(cfg.total));
  assign sync_win = en && (cnt < cfg.sync);
  assign act_win  = en && (cnt_x >= act_lo) && (cnt_x < act_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (last)  cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  // R2/R3: a step that is not a wrap moves the count by exactly one
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !last) |=> (cnt == $past(cnt) + 1'b1));
  // R2/R3: a wrap returns the count to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt == '0));
  // R11: a disabled axis sits at zero
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
#(
  parameter vtg_axis_t H_RST = '{total: 12'd800, act: 12'd640, sync: 12'd96, gap: 12'd48},
  parameter vtg_axis_t V_RST = '{total: 12'd525, act: 12'd480, sync: 12'd2,  gap: 12'd33}
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd,
  input  logic      boundary,
  input  vtg_axis_t stage_h,
  input  vtg_axis_t stage_v,
  output vtg_axis_t work_h,
  output vtg_axis_t work_v
);
  logic pend_q, armed, load;

  assign armed = pend_q | upd;
  assign load  = armed & boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      work_h <= H_RST;
      work_v <= V_RST;
    end else begin
      pend_q <= armed & ~load;
      if (load) begin
        work_h <= stage_h;
        work_v <= stage_v;
      end
    end
  end

  // R5: working timing moves only on a load
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(work_h) && $stable(work_v)));
  // R5: a load takes the staged values present at that edge
  a_r5_take: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((work_h == $past(stage_h)) && (work_v == $past(stage_v))));
endmodule

// File: rtl/vtg_irq.sv
module vtg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic mask_en,
  output logic raw,
  output logic status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    raw <= 1'b0;
    else if (evt)  raw <= 1'b1;
    else if (clr)  raw <= 1'b0;
  end

  assign status = raw & mask_en;

  // R8: a counted underflow is always recorded, even under a clear
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> raw);
  // R9: a clear with no event drops the raw bit
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !raw);
  // R9: with neither input the raw bit keeps its value
  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> (raw == $past(raw)));
endmodule

// File: rtl/vtg_dpi_timing.sv
module vtg_dpi_timing
  import vtg_pkg::*;
#(
  parameter int unsigned PW          = VTG_PW,
  parameter int unsigned H_TOTAL_RST = 800,
  parameter int unsigned H_ACT_RST   = 640,
  parameter int unsigned H_SYNC_RST  = 96,
  parameter int unsigned H_GAP_RST   = 48,
  parameter int unsigned V_TOTAL_RST = 525,
  parameter int unsigned V_ACT_RST   = 480,
  parameter int unsigned V_SYNC_RST  = 2,
  parameter int unsigned V_GAP_RST   = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [VTG_CW-1:0] cfg_h_total,
  input  logic [VTG_CW-1:0] cfg_h_active,
  input  logic [VTG_CW-1:0] cfg_h_sync,
  input  logic [VTG_CW-1:0] cfg_h_gap,
  input  logic [VTG_CW-1:0] cfg_v_total,
  input  logic [VTG_CW-1:0] cfg_v_active,
  input  logic [VTG_CW-1:0] cfg_v_sync,
  input  logic [VTG_CW-1:0] cfg_v_gap,
  input  logic              cfg_update,
  input  logic [PW-1:0]     fill_word,
  input  logic [VTG_CW-1:0] irq_line_min,
  input  logic              irq_enable,
  input  logic              irq_clear,
  input  logic              pix_valid,
  input  logic [PW-1:0]     pix_data,
  output logic              pix_ready,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PW-1:0]     pix_out,
  output logic              irq_raw,
  output logic              irq_status,
  input  logic              ctl_shutdown,
  input  logic              ctl_colour,
  input  logic              ctl_refresh,
  output logic              out_shutdown,
  output logic              out_colour,
  output logic              out_refresh
);
  localparam int unsigned CW = VTG_CW;
  localparam vtg_axis_t H_RST = '{total: CW'(H_TOTAL_RST), act: CW'(H_ACT_RST),
                                  sync: CW'(H_SYNC_RST), gap: CW'(H_GAP_RST)};
  localparam vtg_axis_t V_RST = '{total: CW'(V_TOTAL_RST), act: CW'(V_ACT_RST),
                                  sync: CW'(V_SYNC_RST), gap: CW'(V_GAP_RST)};

  vtg_axis_t stage_h, stage_v, work_h, work_v;
  logic [CW-1:0] h_cnt, v_cnt;
  logic h_last, v_last, h_sync_w, v_sync_w, h_act_w, v_act_w;
  logic frame_end, underrun;

  assign stage_h = '{total: cfg_h_total, act: cfg_h_active, sync: cfg_h_sync, gap: cfg_h_gap};
  assign stage_v = '{total: cfg_v_total, act: cfg_v_active, sync: cfg_v_sync, gap: cfg_v_gap};

  vtg_shadow #(.H_RST(H_RST), .V_RST(V_RST)) u_shadow (
    .clk(clk), .rst_n(rst_n), .upd(cfg_update), .boundary(~run_en | frame_end),
    .stage_h(stage_h), .stage_v(stage_v), .work_h(work_h), .work_v(work_v)
  );

  vtg_axis u_h (
    .clk(clk), .rst_n(rst_n), .en(run_en), .step(1'b1), .cfg(work_h),
    .cnt(h_cnt), .last(h_last), .sync_win(h_sync_w), .act_win(h_act_w)
  );

  vtg_axis u_v (
    .clk(clk), .rst_n(rst_n), .en(run_en), .step(h_last), .cfg(work_v),
    .cnt(v_cnt), .last(v_last), .sync_win(v_sync_w), .act_win(v_act_w)
  );

  assign frame_end = v_last;
  assign hsync     = h_sync_w;
  assign vsync     = v_sync_w;
  assign de        = h_act_w & v_act_w;
  assign pix_ready = de;
  assign pix_out   = !de ? '0 : (pix_valid ? pix_data : fill_word);
  assign underrun  = de & ~pix_valid & (v_cnt >= irq_line_min);

  vtg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(underrun), .clr(irq_clear),
    .mask_en(irq_enable), .raw(irq_raw), .status(irq_status)
  );

  assign out_shutdown = ctl_shutdown;
  assign out_colour   = ctl_colour;
  assign out_refresh  = ctl_refresh;

  // R4: the active region never overlaps either sync pulse
  a_r4_de_clear_of_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));
  // R11: disabled generator leaves both counters at zero
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ((h_cnt == '0) && (v_cnt == '0)));
  // R3: the line count only moves on a pixel wrap
  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !h_last) |=> $stable(v_cnt));
endmodule

// File: tb/tb_vtg_dpi_timing.sv
`timescale 1ns/1ps
module tb_vtg_dpi_timing;
  localparam int PW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic [11:0] cfg_h_total = '0, cfg_h_active = '0, cfg_h_sync = '0, cfg_h_gap = '0;
  logic [11:0] cfg_v_total = '0, cfg_v_active = '0, cfg_v_sync = '0, cfg_v_gap = '0;
  logic cfg_update = 1'b0;
  logic [PW-1:0] fill_word = 30'h2AAA5555;
  logic [11:0] irq_line_min = 12'd7;
  logic irq_enable = 1'b0, irq_clear = 1'b0;
  logic pix_valid = 1'b1;
  logic [PW-1:0] pix_data = '0;
  logic pix_ready, hsync, vsync, de, irq_raw, irq_status;
  logic [PW-1:0] pix_out;
  logic ctl_shutdown = 1'b0, ctl_colour = 1'b0, ctl_refresh = 1'b0;
  logic out_shutdown, out_colour, out_refresh;

  always #2.5 clk = ~clk;

  vtg_dpi_timing dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .cfg_h_total(cfg_h_total), .cfg_h_active(cfg_h_active), .cfg_h_sync(cfg_h_sync), .cfg_h_gap(cfg_h_gap),
    .cfg_v_total(cfg_v_total), .cfg_v_active(cfg_v_active), .cfg_v_sync(cfg_v_sync), .cfg_v_gap(cfg_v_gap),
    .cfg_update(cfg_update), .fill_word(fill_word), .irq_line_min(irq_line_min),
    .irq_enable(irq_enable), .irq_clear(irq_clear), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
    .irq_raw(irq_raw), .irq_status(irq_status),
    .ctl_shutdown(ctl_shutdown), .ctl_colour(ctl_colour), .ctl_refresh(ctl_refresh),
    .out_shutdown(out_shutdown), .out_colour(out_colour), .out_refresh(out_refresh)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model: working timing, staged timing, counters, pending strobe
  int wht = 800, wha = 640, whs = 96, whg = 48;
  int wvt = 525, wva = 480, wvs = 2, wvg = 33;
  int eh = 0, ev = 0, fr = 0, phase = 0;
  bit pend = 0, exp_raw = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (frame %0d line %0d pixel %0d)", req, act, exp, fr, ev, eh);
    end
  endtask

  function automatic bit drop_now();
    if (phase == 0) return 0;
    if (fr == 1 && ev == 5 && eh == 8)  return 1;  // below floor
    if (fr == 1 && ev == 8 && eh == 10) return 1;  // counts
    if (fr == 2 && ev == 8 && eh == 9)  return 1;  // counts, same cycle as clear
    if (fr == 3 && ev == 3 && eh == 5)  return 1;  // below floor
    return 0;
  endfunction

  function automatic bit clr_now();
    if (phase == 0) return 0;
    if (fr == 1 && ev == 8 && eh == 15) return 1;
    if (fr == 2 && ev == 8 && eh == 9)  return 1;
    if (fr == 3 && ev == 0 && eh == 0)  return 1;
    return 0;
  endfunction

  task automatic step();
    bit en, xhs, xvs, xde, evt, hl, vl, bnd, ld;
    logic [PW-1:0] xpix;
    en = run_en;
    pix_valid = !drop_now();
    pix_data  = PW'(fr * 100003 + ev * 211 + eh * 7 + 5);
    irq_clear = clr_now();
    #1;
    xhs = en && (eh < whs);
    xvs = en && (ev < wvs);
    xde = en && (eh >= whs + whg) && (eh < whs + whg + wha) && (ev >= wvs + wvg) && (ev < wvs + wvg + wva);
    xpix = !xde ? '0 : (pix_valid ? pix_data : fill_word);
    chk(hsync == xhs, "R2 hsync", hsync, xhs);
    chk(vsync == xvs, "R3 vsync", vsync, xvs);
    chk(de == xde, "R4 de", de, xde);
    chk(pix_ready == xde, "R6 pix_ready", pix_ready, xde);
    chk(pix_out == xpix, pix_valid ? "R6 pix_out" : "R7 fill", pix_out, xpix);
    chk(irq_raw == exp_raw, "R8 irq_raw", irq_raw, exp_raw);
    chk(irq_status == (exp_raw & irq_enable), "R10 irq_status", irq_status, exp_raw & irq_enable);
    if (!en) chk(!hsync && !vsync && !de, "R11 idle outputs", {hsync, vsync, de}, 0);
    // advance model to the next edge
    evt = xde && !pix_valid && (ev >= int'(irq_line_min));
    exp_raw = evt | (exp_raw & !irq_clear);
    hl = en && (eh >= wht - 1);
    vl = hl && (ev >= wvt - 1);
    bnd = !en || vl;
    ld = (pend || cfg_update) && bnd;
    pend = (pend || cfg_update) && !ld;
    if (!en) begin eh = 0; ev = 0; end
    else if (hl) begin
      eh = 0;
      if (vl) begin ev = 0; if (phase == 1) fr++; end
      else ev++;
    end else eh++;
    if (ld) begin
      wht = cfg_h_total; wha = cfg_h_active; whs = cfg_h_sync; whg = cfg_h_gap;
      wvt = cfg_v_total; wva = cfg_v_active; wvs = cfg_v_sync; wvg = cfg_v_gap;
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of all outputs
    chk(!hsync && !vsync && !de && pix_out == '0, "R1 reset video", {hsync, vsync, de}, 0);
    chk(!irq_raw && !irq_status, "R1 reset irq", {irq_raw, irq_status}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: sideband passthrough in two patterns
    ctl_shutdown = 1; ctl_colour = 0; ctl_refresh = 1; #1;
    chk({out_shutdown, out_colour, out_refresh} == 3'b101, "R12 sideband", {out_shutdown, out_colour, out_refresh}, 3'b101);
    ctl_shutdown = 0; ctl_colour = 1; ctl_refresh = 0; #1;
    chk({out_shutdown, out_colour, out_refresh} == 3'b010, "R12 sideband", {out_shutdown, out_colour, out_refresh}, 3'b010);
    @(negedge clk);
    // R1: run on reset-default timing for part of the first line
    run_en = 1'b1;
    repeat (120) step();
    // R11: disabling holds everything low and restarts the counters
    run_en = 1'b0;
    repeat (3) step();
    // R5: stage config A and load it while disabled
    cfg_h_total = 20; cfg_h_active = 8; cfg_h_sync = 3; cfg_h_gap = 4;
    cfg_v_total = 12; cfg_v_active = 5; cfg_v_sync = 2; cfg_v_gap = 3;
    cfg_update = 1'b1; step(); cfg_update = 1'b0; step();
    phase = 1; fr = 0;
    run_en = 1'b1;
    while (fr < 4) begin
      irq_enable = (fr >= 2);
      if (fr == 1 && ev == 2 && eh == 0) begin
        // R5: mid-frame strobe with config B; must wait for the frame end
        cfg_h_total = 16; cfg_h_active = 6; cfg_h_sync = 2; cfg_h_gap = 3;
        cfg_v_total = 14; cfg_v_active = 6; cfg_v_sync = 1; cfg_v_gap = 2;
        cfg_update = 1'b1;
      end else cfg_update = 1'b0;
      step();
    end
    cfg_update = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule